// File: doc/BRIEF.md
# Byte-Lane Dual-Port Synchronous RAM

This block is a two-port synchronous memory with 36-bit words split into four 9-bit lanes. Two requesters share one storage array, and each reaches it through its own port. Every port has a word address, write data, an active-low write select, a chip-select pair, an active-low lane enable per byte and an asynchronous active-low output enable. Both ports may read or write any location in the same cycle, and any mix of lanes may be touched in one access.

A static input on each port sets its read latency. In flow-through mode the data for an address sampled at one edge is present after that same edge. In pipelined mode it arrives one edge later. Tristate outputs are replaced by a per-lane valid vector. A lane that is not driven shows valid low and reads as zero, so the block can be synthesized and can be placed inside a larger chip.

Both ports share one clock edge, and storage depth is a parameter. When both ports write the same lane of the same word in one cycle, port A's data is stored.

Top module: `bdp_ram`

## Requirements
- R1: While `rst_n` is low and on the first sample after it rises, both ports show `valid` = 0 and `rdata` = 0.
- R2: A port is enabled only when `sel_n` is 0 and `sel` is 1. With any other pair, no lane of that port is written, and its `valid` is 0 after the edge where that pair was sampled (with the port's latency).
- R3: On an enabled write (`wr_n` = 0), only lanes i with `byte_n[i]` = 0 are stored, and the other lanes of the word keep their contents. Lane i is word bits 9*i through 9*i+8.
- R4: On an enabled read (`wr_n` = 1) with `oe_n` = 0, `valid[i]` is 1 exactly for lanes with `byte_n[i]` = 0. The `rdata` bits of every lane whose `valid` bit is 0 read as zero.
- R5: With `flow` = 1, read data and valid bits for the controls sampled at edge n appear after edge n and hold until edge n+1.
- R6: With `flow` = 0, read data and valid bits for the controls sampled at edge n appear after edge n+1.
- R7: `oe_n` acts without a clock. While it is 1, `valid` is 0 and `rdata` is 0. Taking it back to 0 restores the pending lanes at once.
- R8: A write cycle drives no read data: the valid bits for a sampled write are 0.
- R9: A read of a word that the other port writes in the same cycle returns the old contents. The next read returns the new contents.
- R10: When both ports write the same word in one cycle, lanes written by only one port take that port's data. Lanes written by both take port A's data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the read-valid pipeline |
| a_flow | input | 1 | Port A latency select: 1 flow-through, 0 pipelined |
| a_sel_n | input | 1 | Port A chip select, active low |
| a_sel | input | 1 | Port A chip select, active high |
| a_wr_n | input | 1 | Port A direction: 0 write, 1 read |
| a_oe_n | input | 1 | Port A asynchronous output enable, active low |
| a_byte_n | input | 4 | Port A lane enables, active low, bit i for lane i |
| a_addr | input | AW | Port A word address, AW = clog2(DEPTH) |
| a_wdata | input | 36 | Port A write data |
| a_rdata | output | 36 | Port A read data, zero in lanes not valid |
| a_valid | output | 4 | Port A per-lane read-valid flags |
| b_flow | input | 1 | Port B latency select: 1 flow-through, 0 pipelined |
| b_sel_n | input | 1 | Port B chip select, active low |
| b_sel | input | 1 | Port B chip select, active high |
| b_wr_n | input | 1 | Port B direction: 0 write, 1 read |
| b_oe_n | input | 1 | Port B asynchronous output enable, active low |
| b_byte_n | input | 4 | Port B lane enables, active low, bit i for lane i |
| b_addr | input | AW | Port B word address |
| b_wdata | input | 36 | Port B write data |
| b_rdata | output | 36 | Port B read data, zero in lanes not valid |
| b_valid | output | 4 | Port B per-lane read-valid flags |

## Verification
The two ports are first run with opposite latency settings, and then with the settings swapped. A mismatch in one edge of delay therefore shows up on both ports and is told apart from a data fault. All sixteen lane-enable patterns are read back over words that were first filled whole and then partly overwritten. This separates a lane-order or masking fault from an addressing fault. The other patterns exercise the edge cases:
- Chip-select pairs other than the enabling one, each sent with a write attempt.
- Output-enable toggles between edges.
- A same-cycle read against a write to the same word.
- Overlapping lane writes from both ports to one word.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
  parameter int LANES  = 4;
  parameter int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef logic [LANES-1:0]  lanes_t;
  typedef logic [WORD_W-1:0] word_t;

  function automatic logic port_on(logic sel_n, logic sel);
    return !sel_n && sel;
  endfunction

  function automatic lanes_t write_lanes(logic on, logic wr_n, lanes_t byte_n);
    return (on && !wr_n) ? ~byte_n : '0;
  endfunction

  function automatic lanes_t read_lanes(logic on, logic wr_n, lanes_t byte_n);
    return (on && wr_n) ? ~byte_n : '0;
  endfunction

  function automatic word_t lane_bits(lanes_t l);
    word_t m;
    for (int i = 0; i < LANES; i++) m[i*LANE_W +: LANE_W] = {LANE_W{l[i]}};
    return m;
  endfunction

  function automatic word_t merge_lanes(word_t old, word_t nw, lanes_t l);
    return (old & ~lane_bits(l)) | (nw & lane_bits(l));
  endfunction
endpackage

// File: rtl/bdp_ctrl.sv
module bdp_ctrl
  import bdp_pkg::*;
(
  input  logic   sel_n,
  input  logic   sel,
  input  logic   wr_n,
  input  lanes_t byte_n,
  output lanes_t wr_l,
  output lanes_t rd_l
);
  logic on;
  assign on   = port_on(sel_n, sel);
  assign wr_l = write_lanes(on, wr_n, byte_n);
  assign rd_l = read_lanes(on, wr_n, byte_n);
endmodule

// File: rtl/bdp_array.sv
module bdp_array
  import bdp_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
)(
  input  logic          clk,
  input  logic [AW-1:0] a_addr,
  input  word_t         a_wdata,
  input  lanes_t        a_wl,
  input  logic [AW-1:0] b_addr,
  input  word_t         b_wdata,
  input  lanes_t        b_wl,
  output word_t         a_q,
  output word_t         b_q
);
  word_t mem [DEPTH];
  logic  same_word;
  word_t a_base;

  assign same_word = (a_addr == b_addr) && (|b_wl);
  assign a_base    = same_word ? merge_lanes(mem[a_addr], b_wdata, b_wl) : mem[a_addr];

  always_ff @(posedge clk) begin
    a_q <= mem[a_addr];
    b_q <= mem[b_addr];
    if ((|b_wl) && !(same_word && (|a_wl)))
      mem[b_addr] <= merge_lanes(mem[b_addr], b_wdata, b_wl);
    if (|a_wl)
      mem[a_addr] <= merge_lanes(a_base, a_wdata, a_wl);
  end
endmodule

// File: rtl/bdp_rdpath.sv
module bdp_rdpath
  import bdp_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   flow,
  input  logic   oe_n,
  input  word_t  q,
  input  lanes_t rd_l,
  output word_t  rdata,
  output lanes_t valid
);
  lanes_t m1, m2;
  word_t  d2;
  lanes_t cur_m;
  word_t  cur_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= '0;
      m2 <= '0;
    end else begin
      m1 <= rd_l;
      m2 <= m1;
    end
  end

  always_ff @(posedge clk) d2 <= q;

  assign cur_m = flow ? m1 : m2;
  assign cur_d = flow ? q : d2;
  assign valid = cur_m & {LANES{~oe_n}};
  assign rdata = cur_d & lane_bits(valid);
endmodule

// File: rtl/bdp_ram.sv
module bdp_ram
  import bdp_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_flow,
  input  logic              a_sel_n,
  input  logic              a_sel,
  input  logic              a_wr_n,
  input  logic              a_oe_n,
  input  logic [LANES-1:0]  a_byte_n,
  input  logic [AW-1:0]     a_addr,
  input  logic [WORD_W-1:0] a_wdata,
  output logic [WORD_W-1:0] a_rdata,
  output logic [LANES-1:0]  a_valid,
  input  logic              b_flow,
  input  logic              b_sel_n,
  input  logic              b_sel,
  input  logic              b_wr_n,
  input  logic              b_oe_n,
  input  logic [LANES-1:0]  b_byte_n,
  input  logic [AW-1:0]     b_addr,
  input  logic [WORD_W-1:0] b_wdata,
  output logic [WORD_W-1:0] b_rdata,
  output logic [LANES-1:0]  b_valid
);
  lanes_t a_wr_lanes, a_rd_lanes, b_wr_lanes, b_rd_lanes;
  word_t  a_q, b_q;

  bdp_ctrl u_ctrl_a (.sel_n(a_sel_n), .sel(a_sel), .wr_n(a_wr_n), .byte_n(a_byte_n),
                     .wr_l(a_wr_lanes), .rd_l(a_rd_lanes));
  bdp_ctrl u_ctrl_b (.sel_n(b_sel_n), .sel(b_sel), .wr_n(b_wr_n), .byte_n(b_byte_n),
                     .wr_l(b_wr_lanes), .rd_l(b_rd_lanes));

  bdp_array #(.DEPTH(DEPTH)) u_array (
    .clk(clk),
    .a_addr(a_addr), .a_wdata(a_wdata), .a_wl(a_wr_lanes),
    .b_addr(b_addr), .b_wdata(b_wdata), .b_wl(b_wr_lanes),
    .a_q(a_q), .b_q(b_q)
  );

  bdp_rdpath u_rd_a (.clk(clk), .rst_n(rst_n), .flow(a_flow), .oe_n(a_oe_n),
                     .q(a_q), .rd_l(a_rd_lanes), .rdata(a_rdata), .valid(a_valid));
  bdp_rdpath u_rd_b (.clk(clk), .rst_n(rst_n), .flow(b_flow), .oe_n(b_oe_n),
                     .q(b_q), .rd_l(b_rd_lanes), .rdata(b_rdata), .valid(b_valid));
endmodule

// File: rtl/bdp_ram_chk.sv
module bdp_ram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       a_flow,
  input logic       a_oe_n,
  input logic       a_wr_n,
  input logic       a_sel_n,
  input logic       a_sel,
  input logic [3:0] a_rd_lanes,
  input logic [3:0] a_valid,
  input logic       b_flow,
  input logic       b_oe_n,
  input logic [3:0] b_rd_lanes,
  input logic [3:0] b_valid
);
  a_r7_oe_blocks_a: assert property (@(posedge clk) disable iff (!rst_n)
    a_oe_n |-> (a_valid == 4'b0));
  a_r7_oe_blocks_b: assert property (@(posedge clk) disable iff (!rst_n)
    b_oe_n |-> (b_valid == 4'b0));
  a_r5_flow_latency_a: assert property (@(posedge clk) disable iff (!rst_n)
    (a_flow && $past(a_flow)) |-> (a_valid == ($past(a_rd_lanes) & {4{~a_oe_n}})));
  a_r5_flow_latency_b: assert property (@(posedge clk) disable iff (!rst_n)
    (b_flow && $past(b_flow)) |-> (b_valid == ($past(b_rd_lanes) & {4{~b_oe_n}})));
  a_r6_pipe_latency_a: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_flow && !$past(a_flow)) |-> (a_valid == ($past(a_rd_lanes, 2) & {4{~a_oe_n}})));
  a_r6_pipe_latency_b: assert property (@(posedge clk) disable iff (!rst_n)
    (!b_flow && !$past(b_flow)) |-> (b_valid == ($past(b_rd_lanes, 2) & {4{~b_oe_n}})));
  a_r8_write_no_data_a: assert property (@(posedge clk) disable iff (!rst_n)
    (a_flow && !a_sel_n && a_sel && !a_wr_n) |=> (!a_flow || a_valid == 4'b0));
endmodule

bind bdp_ram bdp_ram_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_flow(a_flow), .a_oe_n(a_oe_n), .a_wr_n(a_wr_n), .a_sel_n(a_sel_n), .a_sel(a_sel),
  .a_rd_lanes(a_rd_lanes), .a_valid(a_valid),
  .b_flow(b_flow), .b_oe_n(b_oe_n), .b_rd_lanes(b_rd_lanes), .b_valid(b_valid)
);

// File: tb/bdp_ram_test.sv
module bdp_ram_test;
  localparam int DEPTH = 64;
  localparam int AW = 6;

  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic        flow  [2];
  logic        seln  [2];
  logic        sl    [2];
  logic        wrn   [2];
  logic        oen   [2];
  logic [3:0]  ben   [2];
  logic [AW-1:0] adr [2];
  logic [35:0] wd    [2];
  logic [35:0] a_rdata, b_rdata;
  logic [3:0]  a_valid, b_valid;

  bdp_ram #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n),
    .a_flow(flow[0]), .a_sel_n(seln[0]), .a_sel(sl[0]), .a_wr_n(wrn[0]), .a_oe_n(oen[0]),
    .a_byte_n(ben[0]), .a_addr(adr[0]), .a_wdata(wd[0]), .a_rdata(a_rdata), .a_valid(a_valid),
    .b_flow(flow[1]), .b_sel_n(seln[1]), .b_sel(sl[1]), .b_wr_n(wrn[1]), .b_oe_n(oen[1]),
    .b_byte_n(ben[1]), .b_addr(adr[1]), .b_wdata(wd[1]), .b_rdata(b_rdata), .b_valid(b_valid)
  );

  // behavioural reference
  logic [35:0] rmem [DEPTH];
  logic [35:0] rq [2];
  logic [35:0] rd2 [2];
  logic [3:0]  rm1 [2];
  logic [3:0]  rm2 [2];
  int checks = 0;
  int errors = 0;

  task automatic model_edge();
    logic [3:0] rl [2];
    logic [3:0] wl [2];
    for (int p = 0; p < 2; p++) begin
      logic on;
      on = (seln[p] == 1'b0) && (sl[p] == 1'b1);
      rl[p] = (on && wrn[p]) ? ~ben[p] : 4'b0;
      wl[p] = (on && !wrn[p]) ? ~ben[p] : 4'b0;
      rd2[p] = rq[p];
      rm2[p] = rm1[p];
      rq[p]  = rmem[adr[p]];
      rm1[p] = rst_n ? rl[p] : 4'b0;
    end
    if (!rst_n) for (int p = 0; p < 2; p++) rm2[p] = 4'b0;
    for (int p = 1; p >= 0; p--)
      for (int i = 0; i < 4; i++)
        if (wl[p][i]) rmem[adr[p]][i*9 +: 9] = wd[p][i*9 +: 9];
  endtask

  task automatic compare(string tag);
    for (int p = 0; p < 2; p++) begin
      logic [3:0]  ev;
      logic [35:0] ed, src, gd;
      logic [3:0]  gv;
      ev  = oen[p] ? 4'b0 : (flow[p] ? rm1[p] : rm2[p]);
      src = flow[p] ? rq[p] : rd2[p];
      ed  = '0;
      for (int i = 0; i < 4; i++) if (ev[i]) ed[i*9 +: 9] = src[i*9 +: 9];
      gv = (p == 0) ? a_valid : b_valid;
      gd = (p == 0) ? a_rdata : b_rdata;
      checks++;
      if (gv !== ev) begin
        errors++;
        $display("FAIL %s port %0d valid got %b exp %b", tag, p, gv, ev);
      end
      checks++;
      if (gd !== ed) begin
        errors++;
        $display("FAIL %s port %0d rdata got %h exp %h", tag, p, gd, ed);
      end
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_edge();
    #3;
    compare(tag);
  endtask

  task automatic drive(int p, logic s_n, logic s, logic w_n, logic [3:0] b_n,
                       logic [AW-1:0] a, logic [35:0] d);
    seln[p] = s_n; sl[p] = s; wrn[p] = w_n; ben[p] = b_n; adr[p] = a; wd[p] = d;
  endtask

  task automatic idle(int p);
    drive(p, 1'b1, 1'b0, 1'b1, 4'hF, '0, '0);
  endtask

  function automatic logic [35:0] pat(int k);
    logic [35:0] v;
    v = 36'h9_3C5A_7E11 ^ (36'(k) * 36'h1_0F2B_3D47);
    return v;
  endfunction

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < DEPTH; k++) rmem[k] = '0;
    for (int p = 0; p < 2; p++) begin
      rq[p] = '0; rd2[p] = '0; rm1[p] = '0; rm2[p] = '0;
      oen[p] = 1'b0; idle(p);
    end
    flow[0] = 1'b1; flow[1] = 1'b0;
    repeat (3) tick("R1");
    // R1: outputs quiet during reset
    checks++;
    if (a_valid !== 4'b0 || b_valid !== 4'b0 || a_rdata !== '0 || b_rdata !== '0) begin
      errors++;
      $display("FAIL R1 reset outputs got %b/%b exp 0000/0000", a_valid, b_valid);
    end
    rst_n = 1'b1;
    tick("R1");

    // R3: full-word fill of 0..15 from A and B, then partial overwrites
    for (int k = 0; k < 8; k++) begin
      drive(0, 1'b0, 1'b1, 1'b0, 4'h0, AW'(k), pat(k));
      drive(1, 1'b0, 1'b1, 1'b0, 4'h0, AW'(k + 8), pat(k + 8));
      tick("R8");
    end
    for (int k = 0; k < 8; k++) begin
      drive(0, 1'b0, 1'b1, 1'b0, 4'(k * 5 + 3), AW'(k), ~pat(k + 20));
      idle(1);
      tick("R3");
    end

    // R4 / R5 / R6: all lane patterns read back, A flow, B pipelined
    for (int k = 0; k < 16; k++) begin
      drive(0, 1'b0, 1'b1, 1'b1, 4'(k), AW'(k % 8), '0);
      drive(1, 1'b0, 1'b1, 1'b1, 4'(15 - k), AW'(k), '0);
      tick((k % 2) ? "R4" : "R5");
    end
    idle(0); idle(1);
    tick("R6"); tick("R6");

    // R2: non-enabling chip-select pairs never write
    drive(0, 1'b1, 1'b1, 1'b0, 4'h0, 6'd2, 36'h0);
    drive(1, 1'b0, 1'b0, 1'b0, 4'h0, 6'd9, 36'h0);
    tick("R2");
    drive(0, 1'b1, 1'b0, 1'b0, 4'h0, 6'd3, 36'h0);
    drive(1, 1'b1, 1'b0, 1'b1, 4'h0, 6'd9, 36'h0);
    tick("R2");
    for (int k = 0; k < 4; k++) begin
      drive(0, 1'b0, 1'b1, 1'b1, 4'h0, AW'(2 + k % 2), '0);
      drive(1, (k == 1), (k != 2), 1'b1, 4'h0, 6'd9, '0);
      tick("R2");
    end

    // R7: output enable changes between edges
    idle(0); idle(1);
    drive(0, 1'b0, 1'b1, 1'b1, 4'h0, 6'd4, '0);
    drive(1, 1'b0, 1'b1, 1'b1, 4'h0, 6'd10, '0);
    tick("R7");
    oen[0] = 1'b1; oen[1] = 1'b1; #1; compare("R7");
    tick("R7");
    oen[0] = 1'b0; #1; compare("R7");
    oen[1] = 1'b0; #1; compare("R7");

    // R9: B reads word 5 while A writes it, then again
    drive(0, 1'b0, 1'b1, 1'b0, 4'h0, 6'd5, 36'hA_BCDE_F012);
    drive(1, 1'b0, 1'b1, 1'b1, 4'h0, 6'd5, '0);
    tick("R9");
    idle(0);
    tick("R9"); tick("R9"); tick("R9");

    // R10: overlapping lane writes from both ports to word 12
    drive(0, 1'b0, 1'b1, 1'b0, 4'b0011, 6'd12, 36'h1_1111_1111);
    drive(1, 1'b0, 1'b1, 1'b0, 4'b1001, 6'd12, 36'h2_2222_2222);
    tick("R10");
    drive(0, 1'b0, 1'b1, 1'b1, 4'h0, 6'd12, '0);
    drive(1, 1'b0, 1'b1, 1'b1, 4'h0, 6'd12, '0);
    tick("R10"); tick("R10"); tick("R10");

    // latency settings swapped: A pipelined, B flow-through
    idle(0); idle(1);
    tick("R6");
    flow[0] = 1'b0; flow[1] = 1'b1;
    tick("R6");
    for (int k = 0; k < 12; k++) begin
      drive(0, 1'b0, 1'b1, (k % 3 != 0), 4'(k), AW'(k), pat(k + 40));
      drive(1, 1'b0, 1'b1, 1'b1, 4'(k + 2), AW'(k), '0);
      tick((k % 2) ? "R5" : "R6");
    end
    idle(0); idle(1);
    tick("R8"); tick("R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule